// File: doc/BRIEF.md
# Dual-Clock Shaped Memory

This block is a simple dual-port embedded memory built around one fixed pool of storage bits (2048 by default). A parameter chooses how that pool is presented as words: 16 bits wide and 128 deep, 8 wide and 256 deep, 4 wide and 512 deep, 2 wide and 1024 deep, or 1 wide and 2048 deep. One port only writes and the other only reads. Each port runs on its own clock, so a producer and a consumer at unrelated frequencies can share the memory.

Each port keeps its own registers. On the write side, the address, the data and the write request are captured on the write clock. A strobe made from the captured request then commits the word on the following write-clock edge. On the read side, the address and the read request are captured on the read clock, and the selected word is loaded into an output register on the next enabled read edge. Each side has its own clock enable and its own asynchronous clear. The clears act only on port registers and never erase stored words. Word N of the selected shape occupies bits N*W to N*W+W-1 of the linear pool.

Top module: `dcshape_ram`

## Requirements
- R1: The parameter WORD_W must be one of 1, 2, 4, 8 or 16. The depth is TOTAL_BITS/WORD_W and the address width is log2 of that depth. With the defaults (2048 bits, WORD_W=8), addresses 0 to 255 are distinct words.
- R2: A write request (`wr_req`=1) seen on a write-clock edge while `wr_ce`=1 is captured on that edge. The word is committed on the next write-clock edge and can be read back after that.
- R3: A read request (`rd_req`=1) seen on a read-clock edge while `rd_ce`=1 captures `rd_addr`. On the next read-clock edge with `rd_ce`=1, `rd_q` takes the word stored at the captured address.
- R4: When the captured read request is 0, an enabled read-clock edge leaves `rd_q` unchanged.
- R5: While `rd_ce`=0, the read-side registers and `rd_q` hold their values, whatever `rd_req` and `rd_addr` do.
- R6: While `wr_ce`=0, the captured write command holds its value and no write is started, so stored words are unchanged.
- R7: `wr_clr`=1 clears the write-side registers at once, without a clock, and cancels a captured write that has not yet been committed. Words already stored are kept.
- R8: `rd_clr`=1 drives `rd_q` and the read-side registers to zero at once, without a clock. Words already stored are kept and can still be read afterwards.
- R9: Writing one address leaves every other address unchanged. This holds at the lowest address (0) and at the highest address (depth-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write-side clock enable |
| wr_clr | input | 1 | Asynchronous clear of write-side registers, active high |
| wr_req | input | 1 | Write request |
| wr_addr | input | AW | Write word address |
| wr_data | input | WORD_W | Write word |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read-side clock enable |
| rd_clr | input | 1 | Asynchronous clear of read-side registers, active high |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_q | output | WORD_W | Registered read word |

## Verification
A write is due in the array two write-clock edges after the bench presents it: one edge captures it and the next commits it. The bench therefore waits until the second write-clock falling edge before it starts any read. Read data is due on the second enabled read-clock edge after the request, and the bench samples `rd_q` at the falling edge that follows. Clears take effect without a clock, so their results are sampled one time unit after the clear is raised. Reads and writes to the same address never overlap in time in the bench.

// File: rtl/dcshape_pkg.sv
package dcshape_pkg;
   // legal word widths for the shared storage pool
   function automatic bit width_legal(input int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
   endfunction
endpackage

// File: rtl/dcshape_wr_port.sv
module dcshape_wr_port #(
   parameter int unsigned AW = 8,
   parameter int unsigned W  = 8
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          clr,
   input  logic          req,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  data,
   output logic [AW-1:0] cmd_addr,
   output logic [W-1:0]  cmd_data,
   output logic          strobe
);
   logic req_q;
   logic fresh_q;

   // command capture, gated by the write-side enable
   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         cmd_addr <= '0;
         cmd_data <= '0;
         req_q    <= 1'b0;
         fresh_q  <= 1'b0;
      end else begin
         fresh_q <= ce;
         if (ce) begin
            cmd_addr <= addr;
            cmd_data <= data;
            req_q    <= req;
         end
      end
   end

   // pulse generator: one strobe per freshly captured request
   assign strobe = req_q & fresh_q;

   assert_strobe_origin_R2: assert property (@(posedge clk) disable iff (clr)
      strobe |-> $past(req && ce));

   assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (clr)
      !ce |=> (!strobe && $stable(cmd_addr) && $stable(cmd_data)));

   assert_clear_state_R7: assert property (@(posedge clk)
      clr |-> (!strobe && cmd_addr == '0 && cmd_data == '0));
endmodule

// File: rtl/dcshape_rd_port.sv
module dcshape_rd_port #(
   parameter int unsigned AW = 8,
   parameter int unsigned W  = 8
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          clr,
   input  logic          req,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  word_in,
   output logic [AW-1:0] addr_q,
   output logic [W-1:0]  q
);
   logic req_q;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         addr_q <= '0;
         req_q  <= 1'b0;
         q      <= '0;
      end else if (ce) begin
         addr_q <= addr;
         req_q  <= req;
         if (req_q) q <= word_in;
      end
   end

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (clr)
      (ce && !req_q) |=> $stable(q));

   assert_ce_hold_R5: assert property (@(posedge clk) disable iff (clr)
      !ce |=> ($stable(q) && $stable(addr_q)));

   assert_clear_state_R8: assert property (@(posedge clk)
      clr |-> (q == '0 && addr_q == '0));
endmodule

// File: rtl/dcshape_array.sv
module dcshape_array #(
   parameter int unsigned TOTAL_BITS = 2048,
   parameter int unsigned W          = 8,
   localparam int unsigned DEPTH     = TOTAL_BITS / W,
   localparam int unsigned AW        = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   // linear pool: word n lives in bits n*W .. n*W+W-1
   logic [TOTAL_BITS-1:0] pool;

   for (genvar n = 0; n < DEPTH; n++) begin : g_word
      always_ff @(posedge wclk) begin
         if (we && waddr == AW'(n)) pool[n*W +: W] <= wdata;
      end
   end

   assign rdata = pool[raddr*W +: W];
endmodule

// File: rtl/dcshape_ram.sv
module dcshape_ram #(
   parameter int unsigned TOTAL_BITS = 2048,
   parameter int unsigned WORD_W     = 8,
   localparam int unsigned DEPTH     = TOTAL_BITS / WORD_W,
   localparam int unsigned AW        = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              wr_ce,
   input  logic              wr_clr,
   input  logic              wr_req,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_ce,
   input  logic              rd_clr,
   input  logic              rd_req,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_q
);
   import dcshape_pkg::*;

   // R1: shape checks at elaboration
   if (!width_legal(WORD_W)) begin : g_bad_width
      $error("dcshape_ram: WORD_W must be 1, 2, 4, 8 or 16");
   end
   if ((TOTAL_BITS % WORD_W) != 0 || (1 << AW) != DEPTH) begin : g_bad_pool
      $error("dcshape_ram: TOTAL_BITS must give a power-of-two depth");
   end

   logic [AW-1:0]     cmd_addr;
   logic [WORD_W-1:0] cmd_data;
   logic              strobe;
   logic [AW-1:0]     rd_addr_q;
   logic [WORD_W-1:0] rd_word;

   dcshape_wr_port #(.AW(AW), .W(WORD_W)) u_wr (
      .clk      (wr_clk),
      .ce       (wr_ce),
      .clr      (wr_clr),
      .req      (wr_req),
      .addr     (wr_addr),
      .data     (wr_data),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .strobe   (strobe)
   );

   dcshape_array #(.TOTAL_BITS(TOTAL_BITS), .W(WORD_W)) u_arr (
      .wclk  (wr_clk),
      .we    (strobe),
      .waddr (cmd_addr),
      .wdata (cmd_data),
      .raddr (rd_addr_q),
      .rdata (rd_word)
   );

   dcshape_rd_port #(.AW(AW), .W(WORD_W)) u_rd (
      .clk     (rd_clk),
      .ce      (rd_ce),
      .clr     (rd_clr),
      .req     (rd_req),
      .addr    (rd_addr),
      .word_in (rd_word),
      .addr_q  (rd_addr_q),
      .q       (rd_q)
   );
endmodule

// File: tb/tb_dcshape_ram.sv
module tb_dcshape_ram;
   localparam int unsigned TOTAL = 2048;
   localparam int unsigned W     = 8;
   localparam int unsigned DEPTH = TOTAL / W;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned NVEC  = 10;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [W-1:0]  d;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{8'd0,   8'hA5}, '{8'd1,   8'h5A}, '{8'd2,   8'h00}, '{8'd3,   8'hFF},
      '{8'd127, 8'h3C}, '{8'd128, 8'hC3}, '{8'd200, 8'h81}, '{8'd254, 8'h7E},
      '{8'd255, 8'h96}, '{8'd17,  8'h11}
   };

   logic          wr_clk = 0, rd_clk = 0;
   logic          wr_ce = 1, wr_clr = 1, wr_req = 0;
   logic          rd_ce = 1, rd_clr = 1, rd_req = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_q;

   int checks = 0, errors = 0;

   always #4   wr_clk = ~wr_clk;   // 125 MHz
   always #5.5 rd_clk = ~rd_clk;   // unrelated read clock

   dcshape_ram #(.TOTAL_BITS(TOTAL), .WORD_W(W)) dut (
      .wr_clk(wr_clk), .wr_ce(wr_ce), .wr_clr(wr_clr), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_ce(rd_ce), .rd_clr(rd_clr), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_q(rd_q)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge wr_clk); wr_req = 1; wr_addr = a; wr_data = d;
      @(negedge wr_clk); wr_req = 0;
      @(negedge wr_clk);
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      @(negedge rd_clk); rd_req = 1; rd_addr = a;
      @(negedge rd_clk); rd_req = 0;
      @(negedge rd_clk);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // reset state (R8)
      #1;
      check("R8 reset clears rd_q", rd_q, '0);
      repeat (3) @(negedge wr_clk);
      wr_clr = 0; rd_clr = 0;

      // vector table: write all, then read all back (R1, R2, R3, R9)
      foreach (VECS[i]) do_write(VECS[i].a, VECS[i].d);
      foreach (VECS[i]) begin
         do_read(VECS[i].a);
         check($sformatf("R2/R3/R9 readback addr %0d", VECS[i].a), rd_q, VECS[i].d);
      end
      do_read(8'd255);
      check("R1 top address distinct from 0 and 127", rd_q, 8'h96);

      // R4: request low keeps the output
      do_read(8'd3);
      @(negedge rd_clk); rd_addr = 8'd0;
      repeat (3) @(negedge rd_clk);
      check("R4 rd_req low holds rd_q", rd_q, 8'hFF);

      // R5: rd_ce low ignores requests
      @(negedge rd_clk); rd_ce = 0; rd_req = 1; rd_addr = 8'd1;
      repeat (3) @(negedge rd_clk);
      check("R5 rd_ce low holds rd_q", rd_q, 8'hFF);
      rd_req = 0; rd_ce = 1;
      repeat (3) @(negedge rd_clk);
      check("R5 re-enabled with no request still holds", rd_q, 8'hFF);

      // R6: wr_ce low blocks writes
      @(negedge wr_clk); wr_ce = 0; wr_req = 1; wr_addr = 8'd2; wr_data = 8'hEE;
      repeat (3) @(negedge wr_clk);
      wr_req = 0;
      @(negedge wr_clk); wr_ce = 1;
      repeat (2) @(negedge wr_clk);
      do_read(8'd2);
      check("R6 wr_ce low starts no write", rd_q, 8'h00);

      // R7: clear between capture and commit cancels the write
      @(negedge wr_clk); wr_req = 1; wr_addr = 8'd17; wr_data = 8'h99;
      @(posedge wr_clk); #1; wr_clr = 1; wr_req = 0;
      @(negedge wr_clk); wr_clr = 0;
      repeat (2) @(negedge wr_clk);
      do_read(8'd17);
      check("R7 cleared command not committed", rd_q, 8'h11);
      do_read(8'd128);
      check("R7 array kept after write clear", rd_q, 8'hC3);

      // R8: read clear is immediate and keeps the array
      do_read(8'd0);
      check("R8 pre-clear read", rd_q, 8'hA5);
      @(negedge rd_clk); rd_clr = 1; #1;
      check("R8 async clear zeroes rd_q", rd_q, '0);
      @(negedge rd_clk); rd_clr = 0;
      do_read(8'd0);
      check("R8 array kept after read clear", rd_q, 8'hA5);

      // R9: overwrite neighbour, others unaffected
      do_write(8'd1, 8'h42);
      do_read(8'd1);
      check("R9 overwrite takes effect", rd_q, 8'h42);
      do_read(8'd0);
      check("R9 neighbour below unchanged", rd_q, 8'hA5);
      do_read(8'd2);
      check("R9 neighbour above unchanged", rd_q, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule